// File: doc/BRIEF.md
# Accumulator with Masked Match Flags and Self-Clear

This block keeps a running sum in a result register and compares that result with a reference value. Some bit positions can be excluded from the compare. Two flags leave the block. One reports that every compared bit equals the reference. The other reports that every compared bit equals the complement of the reference. Both flags are registered on the same edge as the sum, so in any cycle they describe the sum that is on the output in that cycle.

The reference is a fixed parameter or the live `c_in` input. The exclusion mask has four possible sources: a fixed parameter, `c_in` taken directly, or `c_in` shifted left by one or two places and then inverted. The two shifted sources serve convergent-rounding schemes. Every low bit that a shift vacates becomes an excluded position.

A self-clear option can zero the sum one edge after a chosen flag condition. The condition is either a plain match, or a match that was present in the previous cycle and is gone in the current one. A parameter decides how the self-clear interacts with the enable. It can override the enable, or it can act only in cycles where the enable is high. All options are static parameters.

Top module: `pattern_detect_acc`

## Requirements
- R1: While `rst_n` is low, every rising edge sets `p_out`, `hit` and `hit_inv` to 0 and clears the remembered previous-cycle match.
- R2: When no self-clear acts, a rising edge with `ce` high loads `p_out + din` (modulo 2^W) into `p_out`. With `ce` low, `p_out` keeps its value.
- R3: `hit` is registered on the same edge as `p_out`. It is 1 exactly when `p_out` equals the reference in every bit where the mask is 0; a mask bit of 1 excludes that position.
- R4: `hit_inv` is computed under the same mask, with the bitwise complement of the reference in place of the reference.
- R5: With `PAT_SRC = PAT_FROM_C`, the reference is the `c_in` value present at the edge. With `PAT_STATIC`, the reference is `STATIC_PAT`.
- R6: With `MASK_SRC = MASK_STATIC`, the mask is `STATIC_MASK`. With `MASK_FROM_C`, the mask is the `c_in` value present at the edge.
- R7: With `MASK_NC_SHL1` the mask is `~(c_in << 1)`, and with `MASK_NC_SHL2` it is `~(c_in << 2)`. The vacated low bits are therefore 1, and those positions are excluded.
- R8: By default the reference is all zeros, and the mask has its two top bits at 0 and every other bit at 1.
- R9: With `AR_MODE = AR_ON_HIT`, a cycle in which `hit` is 1 makes the next edge load 0 into `p_out`, subject to R11 and R12.
- R10: With `AR_MODE = AR_ON_LOSS`, a cycle in which `hit` is 0 and `hit` was 1 in the previous cycle makes the next edge load 0 into `p_out`, subject to R11 and R12.
- R11: With `AR_PRIO = PRIO_RESET`, a pending self-clear zeroes `p_out` even when `ce` is low.
- R12: With `AR_PRIO = PRIO_ENABLE`, a pending self-clear acts only when `ce` is high. When `ce` is low, `p_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Enable of the result register |
| din | input | W | Addend for the running sum |
| c_in | input | W | Dynamic reference or mask source |
| p_out | output | W | Registered running sum |
| hit | output | 1 | Masked match against the reference |
| hit_inv | output | 1 | Masked match against the complemented reference |

## Verification
The assertions assume that `ce`, `din` and `c_in` carry known values at every rising edge once reset is released. They also assume that `rst_n` changes only away from the edge, because the self-clear condition they track is rebuilt from the `hit` flag cycle by cycle. The stimulus meets these assumptions: all inputs are driven on the falling edge from deterministic arithmetic sequences. The sequences include long stretches with `ce` low, and they pass through a reset in the middle of the run, so the history of the previous-cycle match restarts from a known point.

// File: rtl/pd_pkg.sv
// Shared option encodings for the masked match accumulator.
package pd_pkg;
    // Source of the compare reference
    typedef enum logic [0:0] {PAT_STATIC, PAT_FROM_C} pat_src_e;
    // Source of the exclusion mask
    typedef enum logic [1:0] {MASK_STATIC, MASK_FROM_C, MASK_NC_SHL1, MASK_NC_SHL2} mask_src_e;
    // Condition that triggers the self-clear of the sum
    typedef enum logic [1:0] {AR_OFF, AR_ON_HIT, AR_ON_LOSS} ar_mode_e;
    // Interaction of the self-clear with the enable
    typedef enum logic [0:0] {PRIO_RESET, PRIO_ENABLE} ar_prio_e;
endpackage

// File: rtl/pd_select.sv
// Picks the compare reference and the exclusion mask.
// Assumes: every choice is static; c_in is sampled at the same edge as the sum.
module pd_select #(
    parameter int                W          = 58,
    parameter pd_pkg::pat_src_e  PAT_SRC    = pd_pkg::PAT_STATIC,
    parameter pd_pkg::mask_src_e MASK_SRC   = pd_pkg::MASK_STATIC,
    parameter logic [W-1:0]      STATIC_PAT = '0,
    parameter logic [W-1:0]      STATIC_MASK = {2'b00, {(W-2){1'b1}}}
) (
    input  logic [W-1:0] c_in,
    output logic [W-1:0] ref_val,
    output logic [W-1:0] mask_val
);
    generate
        // Reference: static parameter or live c_in
        if (PAT_SRC == pd_pkg::PAT_FROM_C) begin : g_pat_c
            assign ref_val = c_in;
        end else begin : g_pat_s
            assign ref_val = STATIC_PAT;
        end

        // Mask: static, direct c_in, or c_in shifted then inverted (vacated bits excluded)
        if (MASK_SRC == pd_pkg::MASK_FROM_C) begin : g_mask_c
            assign mask_val = c_in;
        end else if (MASK_SRC == pd_pkg::MASK_NC_SHL1) begin : g_mask_s1
            assign mask_val = ~{c_in[W-2:0], 1'b0};
        end else if (MASK_SRC == pd_pkg::MASK_NC_SHL2) begin : g_mask_s2
            assign mask_val = ~{c_in[W-3:0], 2'b00};
        end else begin : g_mask_st
            assign mask_val = STATIC_MASK;
        end
    endgenerate
endmodule

// File: rtl/pd_compare.sv
// Masked equality of a value against a reference and against its complement.
// Assumes: a mask bit of 1 removes that position from both compares.
module pd_compare #(
    parameter int W = 58
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] mask_val,
    output logic         eq,
    output logic         eq_inv
);
    logic [W-1:0] diff_pos;
    logic [W-1:0] diff_neg;

    // Per-bit agreement, forced true where excluded
    always_comb begin
        diff_pos = (value ^ ref_val) & ~mask_val;
        diff_neg = (value ^ ~ref_val) & ~mask_val;
        eq       = (diff_pos == '0);
        eq_inv   = (diff_neg == '0);
    end
endmodule

// File: rtl/pd_autoreset.sv
// Decides whether the sum must be cleared at the coming edge.
// Assumes: hit_q is the registered match flag for the value now on the output.
module pd_autoreset #(
    parameter pd_pkg::ar_mode_e AR_MODE = pd_pkg::AR_OFF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_q,
    output logic clear_req
);
    logic hit_prev;

    // Remember last cycle's match flag
    always_ff @(posedge clk) begin
        if (!rst_n) hit_prev <= 1'b0;
        else        hit_prev <= hit_q;
    end

    generate
        // Trigger condition chosen by the mode
        if (AR_MODE == pd_pkg::AR_ON_HIT) begin : g_on_hit
            assign clear_req = hit_q;
        end else if (AR_MODE == pd_pkg::AR_ON_LOSS) begin : g_on_loss
            assign clear_req = hit_prev & ~hit_q;
        end else begin : g_off
            assign clear_req = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pd_acc.sv
// Result register with enable, self-clear, and the flags registered alongside it.
// Assumes: hit_d and hit_inv_d are computed from p_next by the caller.
module pd_acc #(
    parameter int               W       = 58,
    parameter pd_pkg::ar_prio_e AR_PRIO = pd_pkg::PRIO_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] din,
    input  logic         clear_req,
    input  logic         hit_d,
    input  logic         hit_inv_d,
    output logic [W-1:0] p_next,
    output logic [W-1:0] p_q,
    output logic         hit_q,
    output logic         hit_inv_q
);
    logic clear_now;

    generate
        // Priority: clear overrides enable, or clear needs enable
        if (AR_PRIO == pd_pkg::PRIO_ENABLE) begin : g_gated
            assign clear_now = clear_req & ce;
        end else begin : g_forced
            assign clear_now = clear_req;
        end
    endgenerate

    // Next sum: clear, add, or hold
    always_comb begin
        if (clear_now)  p_next = '0;
        else if (ce)    p_next = p_q + din;
        else            p_next = p_q;
    end

    // Sum and both flags share one edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q       <= '0;
            hit_q     <= 1'b0;
            hit_inv_q <= 1'b0;
        end else begin
            p_q       <= p_next;
            hit_q     <= hit_d;
            hit_inv_q <= hit_inv_d;
        end
    end
endmodule

// File: rtl/pattern_detect_acc.sv
// Top: running sum with masked match flags and optional self-clear.
// Assumes: W >= 3; all option parameters fixed at elaboration.
module pattern_detect_acc #(
    parameter int                W           = 58,
    parameter pd_pkg::pat_src_e  PAT_SRC     = pd_pkg::PAT_STATIC,
    parameter pd_pkg::mask_src_e MASK_SRC    = pd_pkg::MASK_STATIC,
    parameter pd_pkg::ar_mode_e  AR_MODE     = pd_pkg::AR_OFF,
    parameter pd_pkg::ar_prio_e  AR_PRIO     = pd_pkg::PRIO_RESET,
    parameter logic [W-1:0]      STATIC_PAT  = '0,
    parameter logic [W-1:0]      STATIC_MASK = {2'b00, {(W-2){1'b1}}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] din,
    input  logic [W-1:0] c_in,
    output logic [W-1:0] p_out,
    output logic         hit,
    output logic         hit_inv
);
    logic [W-1:0] ref_val;
    logic [W-1:0] mask_val;
    logic [W-1:0] p_next;
    logic         eq;
    logic         eq_inv;
    logic         clear_req;

    pd_select #(
        .W(W), .PAT_SRC(PAT_SRC), .MASK_SRC(MASK_SRC),
        .STATIC_PAT(STATIC_PAT), .STATIC_MASK(STATIC_MASK)
    ) u_select (
        .c_in(c_in), .ref_val(ref_val), .mask_val(mask_val)
    );

    pd_compare #(.W(W)) u_compare (
        .value(p_next), .ref_val(ref_val), .mask_val(mask_val),
        .eq(eq), .eq_inv(eq_inv)
    );

    pd_autoreset #(.AR_MODE(AR_MODE)) u_autoreset (
        .clk(clk), .rst_n(rst_n), .hit_q(hit), .clear_req(clear_req)
    );

    pd_acc #(.W(W), .AR_PRIO(AR_PRIO)) u_acc (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din),
        .clear_req(clear_req), .hit_d(eq), .hit_inv_d(eq_inv),
        .p_next(p_next), .p_q(p_out), .hit_q(hit), .hit_inv_q(hit_inv)
    );
endmodule

// File: rtl/pd_checker.sv
// Temporal checks on the sum, observed at the top ports only.
// Assumes: inputs are known at every edge after reset release.
module pd_checker #(
    parameter int               W       = 58,
    parameter pd_pkg::ar_mode_e AR_MODE = pd_pkg::AR_OFF,
    parameter pd_pkg::ar_prio_e AR_PRIO = pd_pkg::PRIO_RESET
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ce,
    input logic [W-1:0] din,
    input logic [W-1:0] p_out,
    input logic         hit
);
    logic seen_prev;
    logic pend;
    logic acts;

    // Own copy of last cycle's flag, seen from the port
    always_ff @(posedge clk) begin
        if (!rst_n) seen_prev <= 1'b0;
        else        seen_prev <= hit;
    end

    // Pending self-clear as the requirements define it
    always_comb begin
        case (AR_MODE)
            pd_pkg::AR_ON_HIT:  pend = hit;
            pd_pkg::AR_ON_LOSS: pend = seen_prev && !hit;
            default:            pend = 1'b0;
        endcase
        acts = pend && (AR_PRIO == pd_pkg::PRIO_RESET || ce);
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (p_out == '0 && !hit));

    // R2
    sum_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !acts) |=> p_out == W'($past(p_out) + $past(din)));

    // R2
    sum_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !acts) |=> $stable(p_out));

    // R9
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acts |=> p_out == '0);

    // R12
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ce && AR_PRIO == pd_pkg::PRIO_ENABLE) |=> $stable(p_out));
endmodule

bind pattern_detect_acc pd_checker #(.W(W), .AR_MODE(AR_MODE), .AR_PRIO(AR_PRIO)) u_pd_checker (
    .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .p_out(p_out), .hit(hit)
);

// File: tb/test_pattern_detect_acc.sv
module test_pattern_detect_acc;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NI = 4;
    localparam int STEPS = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] c_in = '0;
    logic [W-1:0] p_o [NI];
    logic         h_o [NI];
    logic         hi_o [NI];

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [W-1:0] mp [NI];
    logic         mh [NI];
    logic         mprev [NI];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Defaults: static zero reference, default mask, no self-clear (R8)
    pattern_detect_acc #(.W(W)) i_pattern_detect_acc (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .c_in(c_in),
        .p_out(p_o[0]), .hit(h_o[0]), .hit_inv(hi_o[0]));

    pattern_detect_acc #(.W(W), .PAT_SRC(pd_pkg::PAT_FROM_C), .MASK_SRC(pd_pkg::MASK_FROM_C),
        .AR_MODE(pd_pkg::AR_ON_HIT), .AR_PRIO(pd_pkg::PRIO_RESET)) i_b (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .c_in(c_in),
        .p_out(p_o[1]), .hit(h_o[1]), .hit_inv(hi_o[1]));

    pattern_detect_acc #(.W(W), .STATIC_PAT(8'h5A), .MASK_SRC(pd_pkg::MASK_NC_SHL1),
        .AR_MODE(pd_pkg::AR_ON_LOSS), .AR_PRIO(pd_pkg::PRIO_ENABLE)) i_c (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .c_in(c_in),
        .p_out(p_o[2]), .hit(h_o[2]), .hit_inv(hi_o[2]));

    pattern_detect_acc #(.W(W), .PAT_SRC(pd_pkg::PAT_FROM_C), .MASK_SRC(pd_pkg::MASK_NC_SHL2),
        .AR_MODE(pd_pkg::AR_ON_HIT), .AR_PRIO(pd_pkg::PRIO_ENABLE)) i_d (
        .clk(clk), .rst_n(rst_n), .ce(ce), .din(din), .c_in(c_in),
        .p_out(p_o[3]), .hit(h_o[3]), .hit_inv(hi_o[3]));

    function automatic logic [W-1:0] ref_of(int k, logic [W-1:0] c);
        case (k)
            0: return 8'h00;
            2: return 8'h5A;
            default: return c;
        endcase
    endfunction

    function automatic logic [W-1:0] mask_of(int k, logic [W-1:0] c);
        case (k)
            0: return 8'h3F;
            1: return c;
            2: return ~(c << 1);
            default: return ~(c << 2);
        endcase
    endfunction

    function automatic string tag_p(int k);
        case (k)
            0: return "R2";
            1: return "R9/R11";
            2: return "R10/R12";
            default: return "R9/R12";
        endcase
    endfunction

    function automatic string tag_h(int k);
        case (k)
            0: return "R3/R8";
            1: return "R5/R6";
            2: return "R3/R7";
            default: return "R5/R7";
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp, int k);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst %0d cycle %0d: actual %0h expected %0h", req, k, cycles, act, exp);
        end
    endtask

    // Model one edge, then compare all instances after it
    task automatic step(logic r, logic e, logic [W-1:0] d, logic [W-1:0] c);
        @(negedge clk);
        rst_n = r; ce = e; din = d; c_in = c;
        for (int k = 0; k < NI; k++) begin
            logic fire;
            logic [W-1:0] np;
            logic [W-1:0] rf;
            logic [W-1:0] mk;
            if (!r) begin
                mp[k] = '0; mh[k] = 1'b0; mprev[k] = 1'b0;
                continue;
            end
            fire = (k == 1 || k == 3) ? mh[k] : (k == 2) ? (mprev[k] && !mh[k]) : 1'b0;
            if (fire && (k == 1 || e)) np = '0;
            else if (e)                np = mp[k] + d;
            else                       np = mp[k];
            rf = ref_of(k, c);
            mk = mask_of(k, c);
            mprev[k] = mh[k];
            mp[k] = np;
            mh[k] = (((np ^ rf) & ~mk) == '0);
            // hit_inv expectation computed in place below
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < NI; k++) begin
            logic exp_inv;
            exp_inv = r ? ((((mp[k] ^ ~ref_of(k, c)) & ~mask_of(k, c))) == '0) : 1'b0;
            check(r ? tag_p(k) : "R1", p_o[k], mp[k], k);
            check(r ? tag_h(k) : "R1", W'(h_o[k]), W'(mh[k]), k);
            check(r ? "R4" : "R1", W'(hi_o[k]), W'(exp_inv), k);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NI; k++) begin
            mp[k] = '0; mh[k] = 1'b0; mprev[k] = 1'b0;
        end
        // R1: reset state with busy inputs
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 8'hA5, 8'h3C);
        for (int i = 0; i < STEPS; i++) begin
            logic r;
            logic e;
            r = !(i >= 900 && i < 903);
            // long ce-low stretch exercises R11/R12 with pending clears
            e = (i >= 1400 && i < 1460) ? (i % 9 == 0) : (i % 7 != 3);
            step(r, e, W'(i * 29 + (i >> 3)), W'((i * 113) ^ (i >> 2)));
        end
        // Exhaustive c_in sweep with the sum frozen: masks and references (R3-R8)
        for (int c = 0; c < 256; c++) step(1'b1, 1'b0, 8'h00, W'(c));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule